// File: doc/BRIEF.md
# Burst Write Data Beat Driver

This block drives the write data of a 64-bit processor bus master. The bus carries its data on two 32-bit halves, a high half and a low half, each with its own output enable. A request says whether the write is a single beat or a four-beat cache-line burst. It also gives a per-lane byte select, a flag that keeps the transfer on the high half only, and up to four 64-bit words. The block stores the request and waits for the external arbiter to raise the data-bus-busy input. It then presents the first word in that same cycle.

The slave paces the transfer with a transfer-acknowledge input. After each acknowledge the block moves to the next word on the following cycle. After the final acknowledge it releases both halves to high impedance and raises a one-cycle done pulse. A request is taken only while the block is idle, and the request-ready output shows when that is the case.

Top module: `wbeat_driver`

## Requirements
- R1: After reset, `req_ready` is 1, `done_o` is 0 and both `dh_oe` and `dl_oe` are 0.
- R2: A single-beat request (`req_burst`=0) presents word 0 for as long as needed and completes after exactly one acknowledge.
- R3: Once a request has been accepted, nothing is driven until `bus_busy` is high. In the first cycle `bus_busy` is high, word 0 is already on the halves with its enables set, without waiting for a clock edge.
- R4: A word stays on the bus while `xfer_ack` is low. The cycle after a cycle with `xfer_ack` high carries the next word.
- R5: A burst (`req_burst`=1) presents words 0, 1, 2, 3 in that order and completes after the fourth acknowledge. Word k is `req_data[64k+63:64k]`.
- R6: In the cycle after the final acknowledge, `dh_oe` and `dl_oe` are both 0 and `done_o` is 1. `done_o` is high for that one cycle only.
- R7: Lane mapping: bits [63:32] of a word go to `dh_o` and bits [31:0] go to `dl_o`. Lane 0 is `dh_o[31:24]`, lane 1 is `dh_o[23:16]`, lane 2 is `dh_o[15:8]` and lane 3 is `dh_o[7:0]`. Lanes 4 to 7 map the same way onto `dl_o`. `req_lanes[i]` selects lane i. The contents of unselected lanes are undefined.
- R8: Half enables. In a burst, both halves are driven. In a single beat, a half is driven only if at least one of its lanes is selected.
- R9: When `req_hionly` is 1, `dl_oe` stays 0 for the whole transfer, burst or single. The high half behaves as in R5 and R8.
- R10: `req_ready` is 1 only when idle. A `req_valid` seen while a transfer is pending or active is ignored. It does not change the data being driven and does not start a further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_burst | input | 1 | 1: four-beat burst, 0: single beat |
| req_hionly | input | 1 | Restrict the transfer to the high half |
| req_lanes | input | 8 | Byte-lane select, bit i is lane i |
| req_data | input | 256 | Four 64-bit words, word k at [64k+63:64k] |
| bus_busy | input | 1 | Data-bus-busy from the arbiter |
| xfer_ack | input | 1 | Transfer acknowledge from the slave |
| dh_o | output | 32 | High-half data |
| dh_oe | output | 1 | High-half output enable |
| dl_o | output | 32 | Low-half data |
| dl_oe | output | 1 | Low-half output enable |
| done_o | output | 1 | One-cycle pulse on bus release |

## Verification
The hardest situations to reach are an acknowledge that arrives in the very first busy cycle, and a request that arrives while the block waits for the bus. In the first case the block skips its registered drive state altogether. The stimulus randomises both the delay before `bus_busy` rises and the number of wait cycles before each acknowledge. Directed transfers force a zero delay with no wait cycles. Other transfers hold `req_valid` high with unrelated data during the wait for the bus, then confirm that the original words go out and that no second transfer follows.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_DRIVE = 2'd2
   } wbd_state_e;
endpackage

// File: rtl/wbd_beat_ctl.sv
module wbd_beat_ctl #(
   parameter int BEATS_MAX = 4,
   localparam int CNT_W = $clog2(BEATS_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             burst,
   input  logic             bus_busy,
   input  logic             ta,
   output logic             drive,
   output logic             idle,
   output logic             done,
   output logic [CNT_W-1:0] beat
);
   import wbd_pkg::*;

   wbd_state_e       st;
   logic [CNT_W-1:0] last;

   if (BEATS_MAX < 2) begin : g_bad_beats
      $error("BEATS_MAX must be at least 2");
   end

   always_comb begin
      drive = (st == ST_DRIVE) || ((st == ST_ARMED) && bus_busy);
      idle  = (st == ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         beat <= '0;
         last <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (start) begin
               st   <= ST_ARMED;
               beat <= '0;
               last <= burst ? CNT_W'(BEATS_MAX - 1) : '0;
            end
         end else if (drive) begin
            if (ta) begin
               if (beat == last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  beat <= beat + 1'b1;
                  st   <= ST_DRIVE;
               end
            end else begin
               st <= ST_DRIVE;
            end
         end
      end
   end
endmodule

// File: rtl/wbd_lane_mux.sv
module wbd_lane_mux #(
   parameter int HALF_W     = 32,
   parameter int LANE_W     = 8,
   parameter int BEATS      = 4,
   parameter bit ZERO_UNSEL = 1'b1,
   localparam int WORD_W    = 2 * HALF_W,
   localparam int STORE_W   = WORD_W * BEATS,
   localparam int LANES     = WORD_W / LANE_W,
   localparam int LANES_H   = HALF_W / LANE_W,
   localparam int CNT_W     = $clog2(BEATS)
) (
   input  logic [STORE_W-1:0] store,
   input  logic [CNT_W-1:0]   beat,
   input  logic [LANES-1:0]   lane_en,
   output logic [HALF_W-1:0]  hi,
   output logic [HALF_W-1:0]  lo
);
   logic [STORE_W-1:0] shifted;
   logic [WORD_W-1:0]  word;

   always_comb begin
      shifted = store >> (WORD_W * int'(beat));
      word    = shifted[WORD_W-1:0];
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int SRC = WORD_W - 1 - l * LANE_W;
      localparam int DST = HALF_W - 1 - (l % LANES_H) * LANE_W;
      logic [LANE_W-1:0] byte_v;
      if (ZERO_UNSEL) begin : g_zero
         assign byte_v = lane_en[l] ? word[SRC -: LANE_W] : '0;
      end else begin : g_pass
         logic unused_en;
         assign unused_en = lane_en[l];
         assign byte_v    = word[SRC -: LANE_W];
      end
      if (l < LANES_H) begin : g_hi
         assign hi[DST -: LANE_W] = byte_v;
      end else begin : g_lo
         assign lo[DST -: LANE_W] = byte_v;
      end
   end
endmodule

// File: rtl/wbeat_driver.sv
module wbeat_driver #(
   parameter int HALF_W      = 32,
   parameter int LANE_W      = 8,
   parameter int BURST_BEATS = 4,
   parameter bit ZERO_UNSEL  = 1'b1,
   localparam int WORD_W     = 2 * HALF_W,
   localparam int LANES      = WORD_W / LANE_W,
   localparam int LANES_H    = HALF_W / LANE_W,
   localparam int STORE_W    = WORD_W * BURST_BEATS,
   localparam int CNT_W      = $clog2(BURST_BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_burst,
   input  logic               req_hionly,
   input  logic [LANES-1:0]   req_lanes,
   input  logic [STORE_W-1:0] req_data,
   input  logic               bus_busy,
   input  logic               xfer_ack,
   output logic [HALF_W-1:0]  dh_o,
   output logic               dh_oe,
   output logic [HALF_W-1:0]  dl_o,
   output logic               dl_oe,
   output logic               done_o
);
   if (HALF_W % LANE_W != 0) begin : g_bad_lane
      $error("HALF_W must be a multiple of LANE_W");
   end

   logic               accept;
   logic               drive;
   logic               idle;
   logic [CNT_W-1:0]   beat;
   logic [STORE_W-1:0] store_q;
   logic [LANES-1:0]   lane_en_q;
   logic               hi_any_q;
   logic               lo_any_q;
   logic               hionly_q;

   assign req_ready = idle;
   assign accept    = req_valid && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q   <= '0;
         lane_en_q <= '0;
         hi_any_q  <= 1'b0;
         lo_any_q  <= 1'b0;
         hionly_q  <= 1'b0;
      end else if (accept) begin
         store_q   <= req_data;
         lane_en_q <= req_lanes | {LANES{req_burst}};
         hi_any_q  <= req_burst || (|req_lanes[LANES_H-1:0]);
         lo_any_q  <= !req_hionly && (req_burst || (|req_lanes[LANES-1:LANES_H]));
         hionly_q  <= req_hionly;
      end
   end

   wbd_beat_ctl #(.BEATS_MAX(BURST_BEATS)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .burst    (req_burst),
      .bus_busy (bus_busy),
      .ta       (xfer_ack),
      .drive    (drive),
      .idle     (idle),
      .done     (done_o),
      .beat     (beat)
   );

   wbd_lane_mux #(
      .HALF_W     (HALF_W),
      .LANE_W     (LANE_W),
      .BEATS      (BURST_BEATS),
      .ZERO_UNSEL (ZERO_UNSEL)
   ) u_mux (
      .store   (store_q),
      .beat    (beat),
      .lane_en (lane_en_q),
      .hi      (dh_o),
      .lo      (dl_o)
   );

   assign dh_oe = drive && hi_any_q;
   assign dl_oe = drive && lo_any_q;
endmodule

// File: rtl/wbeat_driver_chk.sv
module wbeat_driver_chk #(
   parameter int HALF_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              xfer_ack,
   input logic              drive,
   input logic              hionly_q,
   input logic [HALF_W-1:0] dh_o,
   input logic              dh_oe,
   input logic              dl_oe,
   input logic              done_o
);
   assert_lo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hionly_q |-> !dl_oe);

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!dh_oe && !dl_oe));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_hold_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && !xfer_ack) |=> (drive && $stable(dh_o)));

   assert_accept_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_no_drive_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !drive);
endmodule

bind wbeat_driver wbeat_driver_chk #(.HALF_W(HALF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .xfer_ack  (xfer_ack),
   .drive     (drive),
   .hionly_q  (hionly_q),
   .dh_o      (dh_o),
   .dh_oe     (dh_oe),
   .dl_oe     (dl_oe),
   .done_o    (done_o)
);

// File: tb/wbeat_driver_test.sv
`timescale 1ns/1ps
module wbeat_driver_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic         req_burst = 1'b0;
   logic         req_hionly = 1'b0;
   logic [7:0]   req_lanes = '0;
   logic [255:0] req_data = '0;
   logic         bus_busy = 1'b0;
   logic         xfer_ack = 1'b0;
   logic [31:0]  dh_o;
   logic         dh_oe;
   logic [31:0]  dl_o;
   logic         dl_oe;
   logic         done_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   wbeat_driver uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_burst(req_burst), .req_hionly(req_hionly), .req_lanes(req_lanes),
      .req_data(req_data), .bus_busy(bus_busy), .xfer_ack(xfer_ack),
      .dh_o(dh_o), .dh_oe(dh_oe), .dl_o(dl_o), .dl_oe(dl_oe), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [63:0] lane_mask(input bit burst, input bit hionly,
                                             input logic [7:0] lanes);
      logic [63:0] m = '0;
      for (int i = 0; i < 8; i++)
         if ((burst || lanes[i]) && (i < 4 || !hionly))
            m[63-8*i -: 8] = 8'hFF;
      return m;
   endfunction

   // R7 / R8 / R9: checks one presented word
   task automatic check_word(input bit burst, input bit hionly, input logic [7:0] lanes,
                             input logic [255:0] data, input int b);
      logic [63:0] word = data[64*b +: 64];
      logic [63:0] m = lane_mask(burst, hionly, lanes);
      bit ehi = burst || (|lanes[3:0]);
      bit elo = !hionly && (burst || (|lanes[7:4]));
      check(dh_oe == ehi, "R8 dh_oe", 64'(dh_oe), 64'(ehi));
      check(dl_oe == elo, hionly ? "R9 dl_oe" : "R8 dl_oe", 64'(dl_oe), 64'(elo));
      check((({dh_o, dl_o}) & m) == (word & m), burst ? "R5/R7 word" : "R2/R7 word",
            {dh_o, dl_o} & m, word & m);
   endtask

   task automatic run_txn(input bit burst, input bit hionly, input logic [7:0] lanes,
                          input logic [255:0] data, input int delay, input bit nogap,
                          input bit intrude);
      int n = burst ? 4 : 1;
      @(negedge clk);
      #1 check(req_ready == 1'b1, "R10 ready idle", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_burst = burst; req_hionly = hionly;
      req_lanes = lanes; req_data = data;
      @(negedge clk);
      req_valid = intrude;
      req_burst = ~burst; req_hionly = ~hionly; req_lanes = ~lanes; req_data = ~data;
      #1 check(req_ready == 1'b0, "R10 ready busy", 64'(req_ready), 64'd0);
      for (int d = 0; d < delay; d++) begin
         #1 check(!dh_oe && !dl_oe, "R3 undriven", {62'd0, dh_oe, dl_oe}, 64'd0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      bus_busy = 1'b1;
      for (int b = 0; b < n; b++) begin
         int gaps = nogap ? 0 : int'($urandom % 3);
         for (int g = 0; g < gaps; g++) begin
            xfer_ack = 1'b0;
            #1 check_word(burst, hionly, lanes, data, b);
            @(negedge clk);
         end
         xfer_ack = 1'b1;
         #1 check_word(burst, hionly, lanes, data, b);
         @(negedge clk);
      end
      xfer_ack = 1'b0;
      #1 check(!dh_oe && !dl_oe, "R6 release", {62'd0, dh_oe, dl_oe}, 64'd0);
      check(done_o == 1'b1, "R6 done", 64'(done_o), 64'd1);
      @(negedge clk);
      #1 check(done_o == 1'b0, "R6 done single", 64'(done_o), 64'd0);
      check(!dh_oe && !dl_oe, "R10 no further transfer", {62'd0, dh_oe, dl_oe}, 64'd0);
      bus_busy = 1'b0;
   endtask

   function automatic logic [255:0] rnd_data();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      void'($urandom(32'd1234));
      #1 check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
      check(!dh_oe && !dl_oe && !done_o, "R1 outputs",
            {61'd0, dh_oe, dl_oe, done_o}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // directed corner cases
      run_txn(1'b0, 1'b0, 8'hFF, rnd_data(), 0, 1'b1, 1'b0);       // R2 ack in first cycle
      run_txn(1'b1, 1'b0, 8'h00, rnd_data(), 0, 1'b1, 1'b0);       // R5 back-to-back acks
      run_txn(1'b1, 1'b1, 8'hFF, rnd_data(), 2, 1'b0, 1'b1);       // R9 burst high only, R10 intrude
      run_txn(1'b0, 1'b1, 8'hF0, rnd_data(), 1, 1'b0, 1'b0);       // R9 only low lanes asked
      run_txn(1'b0, 1'b0, 8'h0F, rnd_data(), 3, 1'b0, 1'b1);       // R8 high half only
      run_txn(1'b0, 1'b0, 8'h81, rnd_data(), 1, 1'b0, 1'b0);       // R7 lanes 0 and 7
      // constrained random
      for (int t = 0; t < 80; t++) begin
         bit   burst  = ($urandom % 2) == 1;
         bit   hionly = ($urandom % 4) == 0;
         logic [7:0] ln = 8'($urandom);
         int   dly    = int'($urandom % 4);
         bit   intr   = ($urandom % 3) == 0;
         run_txn(burst, hionly, ln, rnd_data(), dly, 1'b0, intr);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule